// File: doc/BRIEF.md
# Hierarchical Four-Way Core Selector

This block picks which of four cores should run a single sequential task, based on the stream of cache-line requests that the task makes. It splits the working set in two. It then splits each half again, so each core ends up owning roughly a quarter of the lines that are touched often. Three splitter states do the work. The root state decides between the core pairs {0,1} and {2,3}. Each of two leaf states decides within one pair. Each state holds a leaky window sum, a drift counter and a saturating filter.

Every request line is hashed as its address modulo 31. Only lines whose hash is below a sampling limit update any state. These sampled lines share one small direct-mapped affinity table, which stores a drift-relative affinity for each line. An even hash steers the update to the root state. An odd hash steers it to a leaf state, and the sign of the root filter picks which leaf. The two-bit target core comes straight from the filter signs. The block that performs the migration reads it.

Top module: `four_way_selector`

## Requirements
- R1: After reset, all three filters, window sums and drift counters are zero and the table holds no valid entry. `core_sel` is 0, and `upd_en` is 0 while `req_valid` is low.
- R2: The hash of a request is `req_line` modulo 31. A request is sampled (`upd_en`=1) only when `req_valid` is high and the hash is below `SAMPLE_LIM` (default 8).
- R3: A sampled request with an even hash updates the root state; `upd_sel` reads 0.
- R4: A sampled request with an odd hash updates the upper leaf (`upd_sel`=1) when the root filter is zero or positive, and the lower leaf (`upd_sel`=2) when the root filter is negative.
- R5: An idle cycle or an unsampled request changes no state. `core_sel` keeps its value.
- R6: A table miss gives the line an affinity of zero, so the filter of the updated state stays unchanged. A miss is an invalid entry, a different tag, or an entry written by a different state. The entry is then written with the current drift of that state.
- R7: On a hit, affinity = stored value − drift of the state. The filter adds the affinity, saturating at its signed limits, and the new sign appears on `core_sel` after the clock edge.
- R8: `core_sel[1]` is 1 when the root filter is negative. `core_sel[0]` is 1 when the active leaf filter is negative. The active leaf is the lower one when `core_sel[1]` is 1 and the upper one otherwise.
- R9: A request updates at most one of the three states. The other two hold every register.
- R10: On each update, the drift of the state steps +1 when its window sum is ≥ 0 and −1 otherwise. The window sum becomes sum + affinity − (sum >>> `WIN_SHIFT`), clamped to its signed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A line request is present this cycle |
| req_line | input | LINE_W | Cache-line address of the request |
| upd_en | output | 1 | The current request is sampled and updates a state |
| upd_sel | output | 2 | State being updated: 0 root, 1 upper leaf, 2 lower leaf |
| core_sel | output | 2 | Target core number from the filter signs |

## Verification
The bench goes after the zero boundary of the root filter. A selector that routed on a strict positive test would send odd lines to the lower leaf straight after reset. It checks hashes of lines above 31 and the all-ones line, where a plain low-bit mask or a fold that fails to close at 31 gives the wrong parity or the wrong sampling. It reuses a line under a different leaf, which a tag-only hit check would treat as a hit and use to push that leaf's filter. A long run of hits on one line is compared cycle by cycle against an arithmetic model of drift, window and filter. A wrong drift sign, a missing leak or a missing clamp would then flip the target core on the wrong request.

// File: rtl/sel4_pkg.sv
package sel4_pkg;
  typedef enum logic [1:0] {
    SID_ROOT = 2'd0,
    SID_UP   = 2'd1,
    SID_LOW  = 2'd2
  } sid_e;
  localparam int NUM_STATES = 3;
  localparam int HASH_MOD   = 31;
endpackage

// File: rtl/sel4_hash.sv
module sel4_hash #(
  parameter int LINE_W = 20
) (
  input  logic [LINE_W-1:0] line_i,
  output logic [4:0]        hash_o
);
  localparam int CH = (LINE_W + 4) / 5;
  localparam int SW = 5 + $clog2(CH + 1) + 1;

  logic [CH*5-1:0] pad;
  logic [SW-1:0]   acc;

  // 32 is congruent to 1 modulo 31: sum the 5-bit chunks, fold, then close 31 to 0
  always_comb begin
    pad = '0;
    pad[LINE_W-1:0] = line_i;
    acc = '0;
    for (int i = 0; i < CH; i++) acc = acc + SW'(pad[i*5 +: 5]);
    for (int k = 0; k < 4; k++) acc = SW'(acc[4:0]) + (acc >> 5);
    hash_o = (acc[4:0] == 5'd31) ? 5'd0 : acc[4:0];
  end
endmodule

// File: rtl/sel4_table.sv
module sel4_table #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 16,
  parameter int D_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [1:0]       sid_i,
  output logic             hit_o,
  output logic [D_W-1:0]   val_o,
  input  logic             wr_en_i,
  input  logic [D_W-1:0]   wr_val_i
);
  localparam int ENT = 1 << IDX_W;

  logic             vld_q [ENT];
  logic [TAG_W-1:0] tag_q [ENT];
  logic [1:0]       sid_q [ENT];
  logic [D_W-1:0]   val_q [ENT];

  always_comb begin
    hit_o = vld_q[idx_i] && (tag_q[idx_i] == tag_i) && (sid_q[idx_i] == sid_i);
    val_o = val_q[idx_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) vld_q[i] <= 1'b0;
    end else if (wr_en_i) begin
      vld_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[idx_i] <= tag_i;
      sid_q[idx_i] <= sid_i;
      val_q[idx_i] <= wr_val_i;
    end
  end
endmodule

// File: rtl/sel4_split.sv
module sel4_split #(
  parameter int D_W       = 12,
  parameter int AR_W      = 12,
  parameter int F_W       = 10,
  parameter int WIN_SHIFT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_i,
  input  logic           hit_i,
  input  logic [D_W-1:0] stored_i,
  output logic [D_W-1:0] drift_o,
  output logic [F_W-1:0] filt_o
);
  localparam int FS_W = ((F_W > D_W) ? F_W : D_W) + 1;
  localparam int AS_W = ((AR_W > D_W) ? AR_W : D_W) + 2;
  localparam logic signed [FS_W-1:0] F_HI = FS_W'((64'sd1 <<< (F_W - 1)) - 1);
  localparam logic signed [FS_W-1:0] F_LO = -F_HI - 1;
  localparam logic signed [AS_W-1:0] A_HI = AS_W'((64'sd1 <<< (AR_W - 1)) - 1);
  localparam logic signed [AS_W-1:0] A_LO = -A_HI - 1;

  logic signed [D_W-1:0]  drift_q, drift_d;
  logic signed [AR_W-1:0] win_q, win_d;
  logic signed [F_W-1:0]  filt_q, filt_d;
  logic signed [D_W-1:0]  aff;
  logic signed [FS_W-1:0] fsum;
  logic signed [AS_W-1:0] wsum;

  always_comb begin
    aff  = hit_i ? ($signed(stored_i) - drift_q) : '0;
    fsum = FS_W'(filt_q) + FS_W'(aff);
    wsum = AS_W'(win_q) + AS_W'(aff) - AS_W'(win_q >>> WIN_SHIFT);
    filt_d  = filt_q;
    win_d   = win_q;
    drift_d = drift_q;
    if (upd_i) begin
      if (fsum > F_HI)      filt_d = F_HI[F_W-1:0];
      else if (fsum < F_LO) filt_d = F_LO[F_W-1:0];
      else                  filt_d = fsum[F_W-1:0];
      if (wsum > A_HI)      win_d = A_HI[AR_W-1:0];
      else if (wsum < A_LO) win_d = A_LO[AR_W-1:0];
      else                  win_d = wsum[AR_W-1:0];
      drift_d = win_q[AR_W-1] ? (drift_q - 1'b1) : (drift_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drift_q <= '0;
      win_q   <= '0;
      filt_q  <= '0;
    end else if (upd_i) begin
      drift_q <= drift_d;
      win_q   <= win_d;
      filt_q  <= filt_d;
    end
  end

  assign drift_o = drift_q;
  assign filt_o  = filt_q;
endmodule

// File: rtl/four_way_selector.sv
module four_way_selector #(
  parameter int LINE_W     = 20,
  parameter int IDX_W      = 4,
  parameter int D_W        = 12,
  parameter int AR_W       = 12,
  parameter int F_W        = 10,
  parameter int WIN_SHIFT  = 2,
  parameter int SAMPLE_LIM = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  output logic              upd_en,
  output logic [1:0]        upd_sel,
  output logic [1:0]        core_sel
);
  import sel4_pkg::*;
  localparam int TAG_W = LINE_W - IDX_W;

  logic [1:0]     rst_sync_q;
  logic           rst_n_i;
  logic [4:0]     hash;
  logic           hit;
  logic [D_W-1:0] stored;
  logic [D_W-1:0] drift [NUM_STATES];
  logic [F_W-1:0] filt  [NUM_STATES];
  logic [NUM_STATES-1:0] upd_vec;
  sid_e           sid;
  logic           root_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  sel4_hash #(.LINE_W(LINE_W)) u_hash (.line_i(req_line), .hash_o(hash));

  always_comb begin
    root_neg = filt[SID_ROOT][F_W-1];
    upd_en   = req_valid && (32'(hash) < SAMPLE_LIM);
    if (!hash[0])     sid = SID_ROOT;
    else if (root_neg) sid = SID_LOW;
    else               sid = SID_UP;
    upd_sel  = sid;
    core_sel = {root_neg, root_neg ? filt[SID_LOW][F_W-1] : filt[SID_UP][F_W-1]};
  end

  sel4_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .D_W(D_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .idx_i    (req_line[IDX_W-1:0]),
    .tag_i    (req_line[LINE_W-1:IDX_W]),
    .sid_i    (sid),
    .hit_o    (hit),
    .val_o    (stored),
    .wr_en_i  (upd_en && !hit),
    .wr_val_i (drift[sid])
  );

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_st
    assign upd_vec[s] = upd_en && (sid == sid_e'(s));
    sel4_split #(.D_W(D_W), .AR_W(AR_W), .F_W(F_W), .WIN_SHIFT(WIN_SHIFT)) u_st (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .upd_i    (upd_vec[s]),
      .hit_i    (hit),
      .stored_i (stored),
      .drift_o  (drift[s]),
      .filt_o   (filt[s])
    );
  end
endmodule

// File: rtl/sel4_chk.sv
module sel4_chk #(
  parameter int F_W        = 10,
  parameter int SAMPLE_LIM = 8
) (
  input logic           clk,
  input logic           rst_n_i,
  input logic           req_valid,
  input logic           upd_en,
  input logic [1:0]     upd_sel,
  input logic [1:0]     core_sel,
  input logic [4:0]     hash,
  input logic           hit,
  input logic [F_W-1:0] fx,
  input logic [F_W-1:0] fu,
  input logic [F_W-1:0] fl
);
  a_r2_hash_range: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_valid |-> (hash < 5'd31));
  a_r3_even_root: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd_en && !hash[0]) |-> (upd_sel == 2'd0));
  a_r4_odd_leaf: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd_en && hash[0]) |-> (upd_sel == (fx[F_W-1] ? 2'd2 : 2'd1)));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    !upd_en |=> ($stable(fx) && $stable(fu) && $stable(fl) && $stable(core_sel)));
  a_r6_miss_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd_en && !hit) |=> ($stable(fx) && $stable(fu) && $stable(fl)));
  a_r9_root_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd_en && upd_sel != 2'd0) |=> $stable(fx));
  a_r9_up_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd_en && upd_sel != 2'd1) |=> $stable(fu));
  a_r9_low_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd_en && upd_sel != 2'd2) |=> $stable(fl));
  a_r8_core_root: assert property (@(posedge clk) disable iff (!rst_n_i)
    core_sel[1] == fx[F_W-1]);
endmodule

bind four_way_selector sel4_chk #(.F_W(F_W), .SAMPLE_LIM(SAMPLE_LIM)) u_chk (
  .clk       (clk),
  .rst_n_i   (rst_n_i),
  .req_valid (req_valid),
  .upd_en    (upd_en),
  .upd_sel   (upd_sel),
  .core_sel  (core_sel),
  .hash      (hash),
  .hit       (hit),
  .fx        (filt[0]),
  .fu        (filt[1]),
  .fl        (filt[2])
);

// File: tb/sim_four_way_selector.sv
module sim_four_way_selector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_line = '0;
  logic        upd_en;
  logic [1:0]  upd_sel;
  logic [1:0]  core_sel;
  int          checks = 0;
  int          errors = 0;
  logic        last_en;
  logic [1:0]  last_sel;

  always #4 clk = ~clk;

  four_way_selector u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .upd_en(upd_en), .upd_sel(upd_sel), .core_sel(core_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [19:0] line);
    @(negedge clk);
    req_valid = 1'b1; req_line = line;
    #1;
    last_en = upd_en; last_sel = upd_sel;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 core after reset", core_sel, 0);
    check("R1 upd_en idle", upd_en, 0);
  endtask

  task automatic t_route();
    do_reset();
    issue(20'd0);       check("R3 line 0 sampled", last_en, 1); check("R3 line 0 root", last_sel, 0);
    issue(20'd31);      check("R2 line 31 hash 0", last_en, 1); check("R3 line 31 root", last_sel, 0);
    issue(20'd1);       check("R4 line 1 upper at zero root", last_sel, 1);
    issue(20'd7);       check("R4 line 7 upper", last_sel, 1);
    issue(20'd8);       check("R2 line 8 unsampled", last_en, 0);
    issue(20'd30);      check("R2 line 30 unsampled", last_en, 0);
    issue(20'd31005);   check("R2 line 31005 sampled", last_en, 1); check("R4 line 31005 odd", last_sel, 1);
    issue(20'hFFFFF);   check("R2 all-ones hash 0", last_en, 1); check("R3 all-ones root", last_sel, 0);
    issue(20'd33);      check("R2 line 33 hash 2", last_sel, 0);
    check("R6 misses leave core", core_sel, 0);
  endtask

  task automatic t_root_split();
    do_reset();
    issue(20'd0);
    check("R6 first touch keeps core", core_sel, 0);
    issue(20'd0);
    check("R7 root filter negative", core_sel, 2);
    issue(20'd1);
    check("R4 odd line to lower leaf", last_sel, 2);
    for (int l = 8; l < 31; l++) begin
      issue(20'(l));
      check("R5 unsampled upd_en", last_en, 0);
      check("R5 unsampled core", core_sel, 2);
    end
    repeat (3) @(negedge clk);
    check("R5 idle core", core_sel, 2);
  endtask

  task automatic t_mismatch();
    do_reset();
    issue(20'd1);
    check("R4 upper first", last_sel, 1);
    issue(20'd0);
    issue(20'd0);
    check("R8 core 2", core_sel, 2);
    issue(20'd1);
    check("R6 other-leaf entry is a miss", core_sel, 2);
    issue(20'd1);
    check("R8 lower leaf negative core 3", core_sel, 3);
    check("R9 root kept", core_sel[1], 1);
  endtask

  task automatic t_model();
    int d = 0, w = 0, f = 0, o = 0, a, wn;
    do_reset();
    for (int i = 0; i < 41; i++) begin
      a = (i == 0) ? 0 : (o - d);
      if (i == 0) o = d;
      f = f + a;
      if (f > 511) f = 511;
      if (f < -512) f = -512;
      wn = w + a - (w >>> 2);
      if (wn > 2047) wn = 2047;
      if (wn < -2048) wn = -2048;
      d = d + ((w >= 0) ? 1 : -1);
      w = wn;
      issue(20'd1);
      check("R10 upper leaf sign vs model", core_sel[0], (f < 0) ? 1 : 0);
      check("R9 root untouched", core_sel[1], 0);
    end
  endtask

  initial begin
    t_reset();
    t_route();
    t_root_split();
    t_mismatch();
    t_model();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule